// File: doc/BRIEF.md
# Sample-Step Conversion Error Monitor

This block watches a stream of ADC output codes taken while the converter digitizes a slow sinusoid, or one just above half the sample rate. Under that stimulus two compared samples should differ by at most about one code, so any larger jump is a sparkle-type conversion error. Each sample's step from a reference sample is graded against a programmable tolerance in codes. The tolerance should cover linearity, clock jitter and system noise, and is typically 16 to 32 codes for a 14-bit converter.

There are two comparison modes. In neighbour mode each sample is compared with the one just before it. In skip-one mode each sample is compared with the sample two positions back, which suits an input just above half the sample rate.

The block counts the valid samples and the errors. It pulses an error flag and records the offending code and its index. It raises a pass flag once a preset number of samples has gone by with no error. Software loads that count: for 95% confidence with zero errors it is about 2.996 divided by the error rate to be proven. Counting goes on after an error, so the run stays usable for longer, reduced-confidence tests.

Top module: `cer_step_monitor`

## Requirements
- R1: In neighbour mode (`skip_mode`=0), a valid sample is in error when the absolute difference between its code and the previous valid sample's code is strictly greater than `step_limit`. A difference equal to the limit is not an error, and a limit of 0 flags any nonzero step.
- R2: In skip-one mode (`skip_mode`=1), every valid sample is compared with the valid sample two positions before it, not with its immediate predecessor.
- R3: After reset, after `clr`, or in any cycle where `skip_mode` differs from its value in the previous cycle, checking restarts. The first valid sample is never checked in neighbour mode, and the first two are never checked in skip-one mode.
- R4: The difference is formed one bit wider than the code, so a full-scale step (0 to 16383 or back) is measured as 16383 and never wraps.
- R5: `err_flag` is high in the clock cycle right after the edge that took an erroneous valid sample, and low otherwise. Cycles with `in_valid`=0 change no counter and no history.
- R6: `samples_seen` increases by one for every valid sample, including after errors. `errors_seen` increases by one for every flagged sample.
- R7: Both counters saturate at all ones instead of wrapping.
- R8: `run_failed` rises with the first error and stays high until `clr`.
- R9: `run_passed` is high exactly when `samples_seen` is at least `goal_samples` and `errors_seen` is zero.
- R10: On each error, `last_bad_code` takes the offending code and `last_bad_index` takes its 0-based position among the valid samples since the last clear. Once `samples_seen` has saturated, the recorded position is its saturated value.
- R11: A high `clr` on a clock edge zeroes both counters, both capture registers, `run_failed`, `err_flag` and the comparison history, and ignores any sample in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters, flags, captures and history |
| in_valid | input | 1 | Qualifies `in_code` this cycle |
| in_code | input | 14 | Unsigned ADC output code |
| skip_mode | input | 1 | 0: compare with previous sample; 1: compare with sample two back |
| step_limit | input | 14 | Largest tolerated step, in codes |
| goal_samples | input | 48 | Sample count needed for a pass |
| err_flag | output | 1 | One-cycle pulse per erroneous sample |
| samples_seen | output | 48 | Saturating count of valid samples |
| errors_seen | output | 32 | Saturating count of errors |
| run_passed | output | 1 | Goal reached with zero errors |
| run_failed | output | 1 | Sticky: at least one error since clear |
| last_bad_code | output | 14 | Code of the latest erroneous sample |
| last_bad_index | output | 48 | 0-based index of the latest erroneous sample |

## Verification
The hardest behaviour to reach from the ports is counter saturation, because the real counters are 48 and 32 bits wide. The bench therefore builds a second instance with 5-bit and 2-bit counters on the same stimulus and drives a long alternating 0/1000 pattern that gives an error on every sample. The re-arming after a mode change is also awkward to reach. The stimulus switches modes in the middle of a stream and follows the switch with steps large enough to be errors if they were checked.

// File: rtl/cer_pkg.sv
package cer_pkg;

  typedef enum logic {
    CMP_NEIGHBOUR = 1'b0,
    CMP_SKIP_ONE  = 1'b1
  } cmp_mode_e;

  // Number of earlier samples a mode needs before it can check one.
  function automatic logic [1:0] history_needed(input cmp_mode_e m);
    return (m == CMP_SKIP_ONE) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/cer_history.sv
module cer_history
  import cer_pkg::*;
#(
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic              skip_mode,
  output logic [CODE_W-1:0] ref_code,
  output logic              armed
);

  logic [CODE_W-1:0] prev1_q;
  logic [CODE_W-1:0] prev2_q;
  logic [1:0]        fill_q;
  cmp_mode_e         mode_q;
  cmp_mode_e         mode_now;
  logic              mode_same;

  assign mode_now  = cmp_mode_e'(skip_mode);
  assign mode_same = (mode_now == mode_q);
  assign armed     = mode_same && (fill_q >= history_needed(mode_now));
  assign ref_code  = (mode_now == CMP_SKIP_ONE) ? prev2_q : prev1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev1_q <= '0;
      prev2_q <= '0;
      fill_q  <= 2'd0;
      mode_q  <= CMP_NEIGHBOUR;
    end else if (clr) begin
      prev1_q <= '0;
      prev2_q <= '0;
      fill_q  <= 2'd0;
      mode_q  <= mode_now;
    end else if (!mode_same) begin
      mode_q <= mode_now;
      if (in_valid) begin
        prev1_q <= in_code;
        fill_q  <= 2'd1;
      end else begin
        fill_q <= 2'd0;
      end
    end else if (in_valid) begin
      prev2_q <= prev1_q;
      prev1_q <= in_code;
      fill_q  <= (fill_q == 2'd2) ? 2'd2 : fill_q + 2'd1;
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr && mode_same) |=> ($stable(prev1_q) && $stable(fill_q)));

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr || !mode_same) |=> (fill_q <= 2'd1));

endmodule

// File: rtl/cer_step_judge.sv
module cer_step_judge #(
  parameter int CODE_W = 14
) (
  input  logic              in_valid,
  input  logic              armed,
  input  logic [CODE_W-1:0] in_code,
  input  logic [CODE_W-1:0] ref_code,
  input  logic [CODE_W-1:0] step_limit,
  output logic [CODE_W:0]   step_mag,
  output logic              step_err
);

  localparam int MAG_W = CODE_W + 1;

  // Absolute distance of two unsigned codes, one bit wider so it cannot wrap.
  function automatic logic [MAG_W-1:0] code_distance(input logic [CODE_W-1:0] a,
                                                     input logic [CODE_W-1:0] b);
    logic [MAG_W-1:0] d;
    d = {1'b0, a} - {1'b0, b};
    return d[MAG_W-1] ? (~d + 1'b1) : d;
  endfunction

  assign step_mag = code_distance(in_code, ref_code);
  assign step_err = in_valid && armed && (step_mag > {1'b0, step_limit});

  // R4
  mag_range_chk: assert final (step_mag <= {1'b0, {CODE_W{1'b1}}});

endmodule

// File: rtl/cer_tally.sv
module cer_tally #(
  parameter int CODE_W = 14,
  parameter int SCNT_W = 48,
  parameter int ECNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic              step_err,
  input  logic [SCNT_W-1:0] goal_samples,
  output logic              err_flag,
  output logic [SCNT_W-1:0] samples_seen,
  output logic [ECNT_W-1:0] errors_seen,
  output logic              run_passed,
  output logic              run_failed,
  output logic [CODE_W-1:0] last_bad_code,
  output logic [SCNT_W-1:0] last_bad_index
);

  localparam logic [SCNT_W-1:0] SMAX = {SCNT_W{1'b1}};
  localparam logic [ECNT_W-1:0] EMAX = {ECNT_W{1'b1}};

  assign run_passed = (samples_seen >= goal_samples) && (errors_seen == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag       <= 1'b0;
      samples_seen   <= '0;
      errors_seen    <= '0;
      run_failed     <= 1'b0;
      last_bad_code  <= '0;
      last_bad_index <= '0;
    end else if (clr) begin
      err_flag       <= 1'b0;
      samples_seen   <= '0;
      errors_seen    <= '0;
      run_failed     <= 1'b0;
      last_bad_code  <= '0;
      last_bad_index <= '0;
    end else begin
      err_flag <= step_err;
      if (in_valid && samples_seen != SMAX) begin
        samples_seen <= samples_seen + 1'b1;
      end
      if (step_err) begin
        if (errors_seen != EMAX) begin
          errors_seen <= errors_seen + 1'b1;
        end
        run_failed     <= 1'b1;
        last_bad_code  <= in_code;
        last_bad_index <= samples_seen;
      end
    end
  end

  // R6
  err_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> ((errors_seen == $past(errors_seen) + 1'b1) || ($past(errors_seen) == EMAX)));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (samples_seen >= $past(samples_seen)));

  // R8
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_failed && !clr) |=> run_failed);

  // R9
  pass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_passed |-> (errors_seen == '0));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (samples_seen == '0 && errors_seen == '0 && !run_failed && !err_flag));

endmodule

// File: rtl/cer_step_monitor.sv
module cer_step_monitor #(
  parameter int CODE_W = 14,
  parameter int SCNT_W = 48,
  parameter int ECNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic              skip_mode,
  input  logic [CODE_W-1:0] step_limit,
  input  logic [SCNT_W-1:0] goal_samples,
  output logic              err_flag,
  output logic [SCNT_W-1:0] samples_seen,
  output logic [ECNT_W-1:0] errors_seen,
  output logic              run_passed,
  output logic              run_failed,
  output logic [CODE_W-1:0] last_bad_code,
  output logic [SCNT_W-1:0] last_bad_index
);

  logic [CODE_W-1:0] ref_code;
  logic              armed;
  logic [CODE_W:0]   step_mag;
  logic              step_err;
  logic              take_sample;

  assign take_sample = in_valid && !clr;

  cer_history #(.CODE_W(CODE_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_code   (in_code),
    .skip_mode (skip_mode),
    .ref_code  (ref_code),
    .armed     (armed)
  );

  cer_step_judge #(.CODE_W(CODE_W)) u_judge (
    .in_valid   (take_sample),
    .armed      (armed),
    .in_code    (in_code),
    .ref_code   (ref_code),
    .step_limit (step_limit),
    .step_mag   (step_mag),
    .step_err   (step_err)
  );

  cer_tally #(.CODE_W(CODE_W), .SCNT_W(SCNT_W), .ECNT_W(ECNT_W)) u_tally (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr            (clr),
    .in_valid       (take_sample),
    .in_code        (in_code),
    .step_err       (step_err),
    .goal_samples   (goal_samples),
    .err_flag       (err_flag),
    .samples_seen   (samples_seen),
    .errors_seen    (errors_seen),
    .run_passed     (run_passed),
    .run_failed     (run_failed),
    .last_bad_code  (last_bad_code),
    .last_bad_index (last_bad_index)
  );

  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> $past(in_valid));

  // R1
  limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_err |-> (step_mag > {1'b0, step_limit})));

endmodule

// File: tb/cer_step_monitor_test.sv
module cer_step_monitor_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        in_valid = 1'b0;
  logic [13:0] in_code = '0;
  logic        skip_mode = 1'b0;
  logic [13:0] step_limit = 14'd16;
  logic [47:0] goal_samples = 48'd10;
  logic [4:0]  goal_small = 5'd31;

  logic        err_flag, run_passed, run_failed;
  logic [47:0] samples_seen, last_bad_index;
  logic [31:0] errors_seen;
  logic [13:0] last_bad_code;

  logic        s_err, s_pass, s_fail;
  logic [4:0]  s_samples, s_index;
  logic [1:0]  s_errors;
  logic [13:0] s_code;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cer_step_monitor uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_code(in_code),
    .skip_mode(skip_mode), .step_limit(step_limit), .goal_samples(goal_samples),
    .err_flag(err_flag), .samples_seen(samples_seen), .errors_seen(errors_seen),
    .run_passed(run_passed), .run_failed(run_failed),
    .last_bad_code(last_bad_code), .last_bad_index(last_bad_index)
  );

  cer_step_monitor #(.CODE_W(14), .SCNT_W(5), .ECNT_W(2)) uut_sat (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_code(in_code),
    .skip_mode(skip_mode), .step_limit(step_limit), .goal_samples(goal_small),
    .err_flag(s_err), .samples_seen(s_samples), .errors_seen(s_errors),
    .run_passed(s_pass), .run_failed(s_fail),
    .last_bad_code(s_code), .last_bad_index(s_index)
  );

  // {valid, skip, code[13:0], expected err} with a limit of 16
  localparam int NVEC = 17;
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 14'd1000,  1'b0},
    {1'b1, 1'b0, 14'd1001,  1'b0},
    {1'b1, 1'b0, 14'd1017,  1'b0},
    {1'b1, 1'b0, 14'd1034,  1'b1},
    {1'b0, 1'b0, 14'd5000,  1'b0},
    {1'b1, 1'b0, 14'd1030,  1'b0},
    {1'b1, 1'b0, 14'd16383, 1'b1},
    {1'b1, 1'b0, 14'd0,     1'b1},
    {1'b1, 1'b1, 14'd8000,  1'b0},
    {1'b1, 1'b1, 14'd100,   1'b0},
    {1'b1, 1'b1, 14'd8010,  1'b0},
    {1'b1, 1'b1, 14'd110,   1'b0},
    {1'b1, 1'b1, 14'd8030,  1'b1},
    {1'b1, 1'b1, 14'd112,   1'b0},
    {1'b0, 1'b1, 14'd0,     1'b0},
    {1'b1, 1'b1, 14'd8046,  1'b0},
    {1'b1, 1'b1, 14'd150,   1'b1}
  };

  task automatic check(input bit ok, input string tag, input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic eq(input string tag, input longint actual, input longint expected);
    check(actual == expected, tag, actual, expected);
  endtask

  // Starts and ends just after a falling edge; the results of the sample are visible at return.
  task automatic step(input bit v, input logic [13:0] c);
    in_valid = v;
    in_code  = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R11 values)
    eq("R11 reset samples", samples_seen, 0);
    eq("R11 reset errors", errors_seen, 0);
    eq("R8 reset fail", run_failed, 0);
    eq("R5 reset err_flag", err_flag, 0);
    eq("R9 reset pass below goal", run_passed, 0);

    // table: R1 R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      skip_mode = VEC[i][15];
      step(VEC[i][16], VEC[i][14:1]);
      check(err_flag == VEC[i][0], $sformatf("R1 R2 R3 R4 R5 vector %0d", i), err_flag, VEC[i][0]);
    end
    eq("R6 samples after table", samples_seen, 15);
    eq("R6 errors after table", errors_seen, 5);
    eq("R8 fail after table", run_failed, 1);
    eq("R10 last code", last_bad_code, 150);
    eq("R10 last index", last_bad_index, 14);
    eq("R9 no pass with errors", run_passed, 0);
    repeat (3) @(negedge clk);
    eq("R8 fail stays high", run_failed, 1);

    // R11 clear
    skip_mode = 1'b0;
    do_clear();
    eq("R11 samples cleared", samples_seen, 0);
    eq("R11 errors cleared", errors_seen, 0);
    eq("R11 fail cleared", run_failed, 0);
    eq("R11 code cleared", last_bad_code, 0);
    eq("R11 index cleared", last_bad_index, 0);
    step(1'b1, 14'd5000);
    eq("R11 history cleared first unchecked", err_flag, 0);

    // R10 R5 capture and pulse width, invalid cycles ignored
    step(1'b1, 14'd5001);
    eq("R1 small step", err_flag, 0);
    step(1'b1, 14'd5100);
    eq("R5 pulse after error", err_flag, 1);
    eq("R10 code captured", last_bad_code, 5100);
    eq("R10 index captured", last_bad_index, 2);
    @(negedge clk);
    eq("R5 pulse one cycle", err_flag, 0);
    step(1'b0, 14'd9999);
    eq("R5 invalid no pulse", err_flag, 0);
    eq("R5 invalid not counted", samples_seen, 3);
    step(1'b1, 14'd5101);
    eq("R5 invalid left history alone", err_flag, 0);

    // R9 pass
    do_clear();
    goal_samples = 48'd8;
    for (int k = 0; k < 7; k++) step(1'b1, 14'(300 + k));
    eq("R9 below goal", run_passed, 0);
    step(1'b1, 14'd307);
    eq("R9 goal reached clean", run_passed, 1);
    step(1'b1, 14'd400);
    eq("R9 pass drops on error", run_passed, 0);
    eq("R8 fail on first error", run_failed, 1);

    // R1 limit zero
    do_clear();
    step_limit = 14'd0;
    step(1'b1, 14'd50);
    step(1'b1, 14'd50);
    eq("R1 zero limit equal codes", err_flag, 0);
    step(1'b1, 14'd51);
    eq("R1 zero limit one code", err_flag, 1);

    // R2 R3 skip-one mode armed from clear
    step_limit = 14'd16;
    skip_mode = 1'b1;
    do_clear();
    step(1'b1, 14'd1000);
    eq("R3 skip first unchecked", err_flag, 0);
    step(1'b1, 14'd9000);
    eq("R3 skip second unchecked", err_flag, 0);
    step(1'b1, 14'd1001);
    eq("R2 compared two back", err_flag, 0);
    step(1'b1, 14'd9100);
    eq("R2 error two back", err_flag, 1);

    // R3 switch back to neighbour mode
    skip_mode = 1'b0;
    step(1'b1, 14'd7000);
    eq("R3 first after mode change", err_flag, 0);
    step(1'b1, 14'd7001);
    eq("R3 armed after one", err_flag, 0);
    step(1'b1, 14'd7100);
    eq("R1 neighbour error", err_flag, 1);

    // R7 saturation
    do_clear();
    for (int k = 0; k < 40; k++) step(1'b1, (k % 2 == 0) ? 14'd0 : 14'd1000);
    eq("R6 wide samples", samples_seen, 40);
    eq("R6 wide errors", errors_seen, 39);
    eq("R7 narrow samples saturate", s_samples, 31);
    eq("R7 narrow errors saturate", s_errors, 3);
    eq("R10 index at saturation", s_index, 31);
    eq("R8 narrow fail", s_fail, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule